// File: doc/BRIEF.md
# Serial Port Register Front-End with Receive FIFO

This block is the bus-facing register side of an asynchronous serial port that has a receive FIFO. Software reaches it through a simple single-cycle read/write bus spanning a 0x28-byte window. It holds the mode, control, FIFO-control and port registers, a write-zero-to-clear status register, and a 16-byte receive queue. The bit-level shifters and the baud-rate generator sit outside. Bytes written for transmission count as sent at once: they leave on a byte-wide output with a one-cycle strobe. Received bytes arrive on a byte-wide input with a valid strobe, and a separate line reports a received break.

Status does not follow a plain non-empty test. The receive-full flag and the receive interrupt follow a trigger threshold that software picks. Flags clear only when software writes zero to them. Writing the control register can force the transmit flags. The transmit interrupt line is a direct copy of one control bit.

Register offsets: mode 0x00, control 0x08, transmit data 0x0C, status 0x10, receive data 0x14, FIFO control 0x18, port 0x20. Any other offset is unmapped.

Top module: `uart_regfront`

## Requirements
- R1: The receive queue holds 16 bytes. A byte offered while 16 are held is dropped and never read back.
- R2: A byte on `rx_data` with `rx_valid` is stored only while control bit 4 (receive enable) is 1.
- R3: FIFO-control bits 7:6 pick the trigger level: code 0 gives 1 byte, 1 gives 4, 2 gives 8, 3 gives 14. A store that brings the count to the trigger level or above sets receive-full (status bit 1).
- R4: `irq_rx` goes high in the cycle after a store that sets receive-full, but only while control bit 6 is 1. It then stays high until one of two writes clears it: a control write with bit 6 = 0, or a status write with bit 1 = 0 or bit 0 = 0.
- R5: A read at 0x14 returns the oldest byte and pops it. Order is first-in first-out across the pointer wrap. If the count left is below the trigger level, receive-full clears. A read of an empty queue returns 0x00 and changes nothing.
- R6: A write at 0x0C shows the byte on `tx_data` with `tx_strobe` high for exactly the next cycle, and clears transmit-empty (status bit 5).
- R7: The status read value has transmit-end at bit 6, transmit-empty at bit 5, break at bit 4, receive-full at bit 1 and data-ready at bit 0. All other bits read 0. Writing 0 to one of these bits clears that flag. Writing 1 leaves it as it is.
- R8: Control keeps write data ANDed with 0xFA. A control write with bit 5 (transmit enable) = 0 sets transmit-end. `irq_tx` equals control bit 7 from the cycle after the write.
- R9: A status read while control bit 5 is 1 returns the current flags, then sets transmit-end and transmit-empty.
- R10: Mode keeps write data ANDed with 0x7B, and port keeps it ANDed with 0xF3. FIFO control keeps it ANDed with 0xFD. A FIFO-control write with bit 1 = 1 empties the receive queue.
- R11: A pulse on `rx_break` sets the break flag (status bit 4). Every stored byte sets data-ready (status bit 0).
- R12: After reset, control reads 0x20, status reads 0x60, and mode, FIFO control and port read 0x00. The receive queue is empty, and both interrupts and `tx_strobe` are low.
- R13: Writes to unmapped offsets (0x04, 0x1C, 0x24, 0x28 and up) change nothing, and reads from them return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rd | input | 1 | Register read strobe; read data is valid in the same cycle |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 6 | Byte offset inside the register window |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, 0 when no read is active |
| tx_data | output | 8 | Byte written for transmission |
| tx_strobe | output | 1 | One-cycle pulse marking a new `tx_data` |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | `rx_data` carries a byte this cycle |
| rx_break | input | 1 | A break condition was received |
| irq_tx | output | 1 | Transmit interrupt |
| irq_rx | output | 1 | Receive interrupt |

## Verification
Corrupted queue pointers or count show up as a read at 0x14 that returns the wrong byte or an unexpected 0x00. This is visible on the first pop after the fault, and for wrap errors only once 16 bytes have been cycled through. A wrong trigger comparison shows as receive-full or `irq_rx` changing one store or one pop too early or too late, and each store and pop is followed by a status read so that this is caught. A flag register that holds or loses a bit wrongly is seen on the next status read, and stale control state is seen on `irq_tx` one cycle after the control write.

// File: rtl/uart_regfront_pkg.sv
package uart_regfront_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 6;

    localparam logic [ADDR_W-1:0] OFS_MODE = 6'h00;
    localparam logic [ADDR_W-1:0] OFS_CTRL = 6'h08;
    localparam logic [ADDR_W-1:0] OFS_TXD  = 6'h0C;
    localparam logic [ADDR_W-1:0] OFS_STAT = 6'h10;
    localparam logic [ADDR_W-1:0] OFS_RXD  = 6'h14;
    localparam logic [ADDR_W-1:0] OFS_FCTL = 6'h18;
    localparam logic [ADDR_W-1:0] OFS_PORT = 6'h20;

    // control register bit positions
    localparam int CTRL_RE  = 4;
    localparam int CTRL_TE  = 5;
    localparam int CTRL_RIE = 6;
    localparam int CTRL_TIE = 7;

    // FIFO control bit positions
    localparam int FCTL_CLR   = 1;
    localparam int FCTL_TRG_L = 6;

    typedef enum logic [2:0] {
        SEL_NONE, SEL_MODE, SEL_CTRL, SEL_TXD,
        SEL_STAT, SEL_RXD, SEL_FCTL, SEL_PORT
    } reg_sel_e;

    // plain configuration registers held in one array
    localparam int NCFG     = 4;
    localparam int IDX_MODE = 0;
    localparam int IDX_CTRL = 1;
    localparam int IDX_FCTL = 2;
    localparam int IDX_PORT = 3;

    localparam reg_sel_e CFG_SEL [NCFG] = '{SEL_MODE, SEL_CTRL, SEL_FCTL, SEL_PORT};
    localparam logic [DATA_W-1:0] CFG_MASK [NCFG] = '{8'h7B, 8'hFA, 8'hFD, 8'hF3};
    localparam logic [DATA_W-1:0] CFG_RST  [NCFG] = '{8'h00, 8'h20, 8'h00, 8'h00};

    typedef struct packed {
        logic tend;
        logic tde;
        logic brk;
        logic rdf;
        logic dr;
    } stat_flags_t;

    typedef struct packed {
        logic                rd;
        logic                wr;
        reg_sel_e            sel;
        logic [DATA_W-1:0]   wdata;
    } bus_req_t;

    function automatic reg_sel_e decode_ofs(logic [ADDR_W-1:0] a);
        reg_sel_e s;
        case (a)
            OFS_MODE: s = SEL_MODE;
            OFS_CTRL: s = SEL_CTRL;
            OFS_TXD:  s = SEL_TXD;
            OFS_STAT: s = SEL_STAT;
            OFS_RXD:  s = SEL_RXD;
            OFS_FCTL: s = SEL_FCTL;
            OFS_PORT: s = SEL_PORT;
            default:  s = SEL_NONE;
        endcase
        return s;
    endfunction

    function automatic int unsigned trig_level(logic [1:0] code);
        int unsigned t;
        case (code)
            2'd0:    t = 1;
            2'd1:    t = 4;
            2'd2:    t = 8;
            default: t = 14;
        endcase
        return t;
    endfunction

    function automatic logic [DATA_W-1:0] pack_stat(stat_flags_t f);
        return {1'b0, f.tend, f.tde, f.brk, 2'b00, f.rdf, f.dr};
    endfunction

endpackage

// File: rtl/uart_cfg_regs.sv
module uart_cfg_regs
    import uart_regfront_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  bus_req_t                      req,
    output logic [NCFG-1:0][DATA_W-1:0]   cfg_q,
    output logic                          fifo_clr,
    output logic                          ctrl_wr
);

    always_ff @(posedge clk) begin
        for (int i = 0; i < NCFG; i++) begin
            if (rst) begin
                cfg_q[i] <= CFG_RST[i];
            end else if (req.wr && req.sel == CFG_SEL[i]) begin
                cfg_q[i] <= req.wdata & CFG_MASK[i];
            end
        end
    end

    assign ctrl_wr  = req.wr && (req.sel == SEL_CTRL);
    assign fifo_clr = req.wr && (req.sel == SEL_FCTL) && req.wdata[FCTL_CLR];

endmodule

// File: rtl/uart_rxq.sv
module uart_rxq #(
    parameter  int DEPTH = 16,
    parameter  int W     = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [W-1:0]     push_data,
    input  logic             pop_req,
    input  logic             clr,
    output logic [W-1:0]     head,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] count_next,
    output logic             stored,
    output logic             popped
);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;

    function automatic logic [PTR_W-1:0] step(logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign stored = push && (count < CNT_W'(DEPTH)) && !clr;
    assign popped = pop_req && (count != '0) && !clr;
    assign head   = mem[rd_ptr];

    always_comb begin
        count_next = count;
        if (clr) begin
            count_next = '0;
        end else begin
            case ({stored, popped})
                2'b10:   count_next = count + 1'b1;
                2'b01:   count_next = count - 1'b1;
                default: count_next = count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            count <= count_next;
            if (clr) begin
                wr_ptr <= '0;
                rd_ptr <= '0;
            end else begin
                if (stored) wr_ptr <= step(wr_ptr);
                if (popped) rd_ptr <= step(rd_ptr);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (stored) mem[wr_ptr] <= push_data;
    end

endmodule

// File: rtl/uart_stat_flags.sv
module uart_stat_flags
    import uart_regfront_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        stat_rd,
    input  logic        stat_wr,
    input  stat_flags_t keep,
    input  logic        ctrl_wr,
    input  logic        ctrl_wr_te,
    input  logic        ctrl_wr_rie,
    input  logic        tx_wr,
    input  logic        te_en,
    input  logic        rie_en,
    input  logic        rx_break,
    input  logic        rx_stored,
    input  logic        rdf_set,
    input  logic        rdf_drop,
    output stat_flags_t flags,
    output logic        irq_rx
);

    stat_flags_t f_n;
    logic        irq_n;

    always_comb begin
        f_n = flags;
        if (stat_rd && te_en) begin
            f_n.tend = 1'b1;
            f_n.tde  = 1'b1;
        end
        if (ctrl_wr && !ctrl_wr_te) f_n.tend = 1'b1;
        if (stat_wr) begin
            if (!keep.tend) f_n.tend = 1'b0;
            if (!keep.tde)  f_n.tde  = 1'b0;
            if (!keep.brk)  f_n.brk  = 1'b0;
            if (!keep.rdf)  f_n.rdf  = 1'b0;
            if (!keep.dr)   f_n.dr   = 1'b0;
        end
        if (tx_wr)     f_n.tde = 1'b0;
        if (rdf_drop)  f_n.rdf = 1'b0;
        if (rx_break)  f_n.brk = 1'b1;
        if (rx_stored) f_n.dr  = 1'b1;
        if (rdf_set)   f_n.rdf = 1'b1;
    end

    always_comb begin
        irq_n = irq_rx;
        if (ctrl_wr && !ctrl_wr_rie)            irq_n = 1'b0;
        if (stat_wr && (!keep.rdf || !keep.dr)) irq_n = 1'b0;
        if (rdf_set && rie_en)                  irq_n = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags  <= '{tend: 1'b1, tde: 1'b1, brk: 1'b0, rdf: 1'b0, dr: 1'b0};
            irq_rx <= 1'b0;
        end else begin
            flags  <= f_n;
            irq_rx <= irq_n;
        end
    end

endmodule

// File: rtl/uart_regfront.sv
module uart_regfront
    import uart_regfront_pkg::*;
#(
    parameter  int RXQ_DEPTH = 16,
    localparam int CNT_W     = $clog2(RXQ_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] tx_data,
    output logic              tx_strobe,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_valid,
    input  logic              rx_break,
    output logic              irq_tx,
    output logic              irq_rx
);

    bus_req_t                      req;
    logic [NCFG-1:0][DATA_W-1:0]   cfg_q;
    logic [DATA_W-1:0]             ctrl_q;
    logic [DATA_W-1:0]             fctl_q;
    logic                          fifo_clr;
    logic                          ctrl_wr;
    logic [DATA_W-1:0]             rx_head;
    logic [CNT_W-1:0]              rx_count;
    logic [CNT_W-1:0]              rx_count_next;
    logic                          rx_stored;
    logic                          rx_popped;
    logic [CNT_W-1:0]              trg;
    logic                          rdf_set;
    logic                          rdf_drop;
    stat_flags_t                   flags;
    stat_flags_t                   keep;
    logic [DATA_W-1:0]             rd_val;

    assign req = '{rd: bus_rd, wr: bus_wr, sel: decode_ofs(bus_addr), wdata: bus_wdata};

    uart_cfg_regs u_cfg (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .cfg_q    (cfg_q),
        .fifo_clr (fifo_clr),
        .ctrl_wr  (ctrl_wr)
    );

    assign ctrl_q = cfg_q[IDX_CTRL];
    assign fctl_q = cfg_q[IDX_FCTL];
    assign irq_tx = ctrl_q[CTRL_TIE];
    assign trg    = CNT_W'(trig_level(fctl_q[FCTL_TRG_L +: 2]));

    uart_rxq #(
        .DEPTH (RXQ_DEPTH),
        .W     (DATA_W)
    ) u_rxq (
        .clk        (clk),
        .rst        (rst),
        .push       (rx_valid && ctrl_q[CTRL_RE]),
        .push_data  (rx_data),
        .pop_req    (req.rd && req.sel == SEL_RXD),
        .clr        (fifo_clr),
        .head       (rx_head),
        .count      (rx_count),
        .count_next (rx_count_next),
        .stored     (rx_stored),
        .popped     (rx_popped)
    );

    assign rdf_set  = rx_stored && (rx_count_next >= trg);
    assign rdf_drop = rx_popped && (rx_count_next < trg);

    assign keep = '{tend: bus_wdata[6], tde: bus_wdata[5], brk: bus_wdata[4],
                    rdf: bus_wdata[1], dr: bus_wdata[0]};

    uart_stat_flags u_stat (
        .clk         (clk),
        .rst         (rst),
        .stat_rd     (req.rd && req.sel == SEL_STAT),
        .stat_wr     (req.wr && req.sel == SEL_STAT),
        .keep        (keep),
        .ctrl_wr     (ctrl_wr),
        .ctrl_wr_te  (bus_wdata[CTRL_TE]),
        .ctrl_wr_rie (bus_wdata[CTRL_RIE]),
        .tx_wr       (req.wr && req.sel == SEL_TXD),
        .te_en       (ctrl_q[CTRL_TE]),
        .rie_en      (ctrl_q[CTRL_RIE]),
        .rx_break    (rx_break),
        .rx_stored   (rx_stored),
        .rdf_set     (rdf_set),
        .rdf_drop    (rdf_drop),
        .flags       (flags),
        .irq_rx      (irq_rx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_strobe <= 1'b0;
            tx_data   <= '0;
        end else begin
            tx_strobe <= req.wr && req.sel == SEL_TXD;
            if (req.wr && req.sel == SEL_TXD) tx_data <= bus_wdata;
        end
    end

    always_comb begin
        case (req.sel)
            SEL_MODE: rd_val = cfg_q[IDX_MODE];
            SEL_CTRL: rd_val = ctrl_q;
            SEL_FCTL: rd_val = fctl_q;
            SEL_PORT: rd_val = cfg_q[IDX_PORT];
            SEL_STAT: rd_val = pack_stat(flags);
            SEL_RXD:  rd_val = (rx_count != '0) ? rx_head : '0;
            default:  rd_val = '0;
        endcase
    end

    assign bus_rdata = bus_rd ? rd_val : '0;

endmodule

// File: rtl/uart_regfront_chk.sv
module uart_regfront_chk
    import uart_regfront_pkg::*;
#(
    parameter  int RXQ_DEPTH = 16,
    localparam int CNT_W     = $clog2(RXQ_DEPTH + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] tx_data,
    input logic              tx_strobe,
    input logic              rx_valid,
    input logic              rx_break,
    input logic              irq_tx,
    input logic              irq_rx,
    input logic              re_en,
    input logic              rie_en,
    input logic              brk_flag,
    input logic [CNT_W-1:0]  rx_count
);

    logic rd_rxd;
    logic fctl_clr;
    assign rd_rxd   = bus_rd && bus_addr == OFS_RXD;
    assign fctl_clr = bus_wr && bus_addr == OFS_FCTL && bus_wdata[FCTL_CLR];

    a_r1_count_bound: assert property (@(posedge clk) disable iff (rst)
        rx_count <= CNT_W'(RXQ_DEPTH));

    a_r1_full_drop: assert property (@(posedge clk) disable iff (rst)
        (rx_count == CNT_W'(RXQ_DEPTH) && rx_valid && !rd_rxd && !fctl_clr)
        |=> rx_count == CNT_W'(RXQ_DEPTH));

    a_r2_rx_gated: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !re_en && !rd_rxd && !fctl_clr) |=> $stable(rx_count));

    a_r4_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_rx) |-> $past(rie_en));

    a_r6_tx_echo: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFS_TXD) |=> (tx_strobe && tx_data == $past(bus_wdata)));

    a_r7_brk_clear: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFS_STAT && !bus_wdata[4] && !rx_break) |=> !brk_flag);

    a_r8_irq_tx_follow: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFS_CTRL) |=> irq_tx == $past(bus_wdata[CTRL_TIE]));

endmodule

bind uart_regfront uart_regfront_chk #(.RXQ_DEPTH(RXQ_DEPTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .tx_data   (tx_data),
    .tx_strobe (tx_strobe),
    .rx_valid  (rx_valid),
    .rx_break  (rx_break),
    .irq_tx    (irq_tx),
    .irq_rx    (irq_rx),
    .re_en     (ctrl_q[4]),
    .rie_en    (ctrl_q[6]),
    .brk_flag  (flags.brk),
    .rx_count  (rx_count)
);

// File: tb/uart_regfront_bench.sv
`timescale 1ns/1ps
module uart_regfront_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [5:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] tx_data;
    logic       tx_strobe;
    logic [7:0] rx_data = '0;
    logic       rx_valid = 1'b0;
    logic       rx_break = 1'b0;
    logic       irq_tx;
    logic       irq_rx;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    uart_regfront u_uart_regfront (
        .clk       (clk),
        .rst       (rst),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .tx_data   (tx_data),
        .tx_strobe (tx_strobe),
        .rx_data   (rx_data),
        .rx_valid  (rx_valid),
        .rx_break  (rx_break),
        .irq_tx    (irq_tx),
        .irq_rx    (irq_rx)
    );

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [5:0] a, logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [5:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic push(logic [7:0] d);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = d;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(6'h08, v); chk("R12 ctrl reset", v, 8'h20);
        rd(6'h10, v); chk("R12 status reset", v, 8'h60);
        rd(6'h00, v); chk("R12 mode reset", v, 8'h00);
        rd(6'h18, v); chk("R12 fctl reset", v, 8'h00);
        rd(6'h20, v); chk("R12 port reset", v, 8'h00);
        rd(6'h14, v); chk("R12 queue empty", v, 8'h00);
        chk("R12 irq/strobe low", {5'b0, irq_tx, irq_rx, tx_strobe}, 8'h00);
    endtask

    task automatic t_masks();
        logic [7:0] v;
        wr(6'h00, 8'hFF); rd(6'h00, v); chk("R10 mode mask", v, 8'h7B);
        wr(6'h20, 8'hFF); rd(6'h20, v); chk("R10 port mask", v, 8'hF3);
        wr(6'h18, 8'hFF); rd(6'h18, v); chk("R10 fctl mask", v, 8'hFD);
        wr(6'h08, 8'hFF); rd(6'h08, v); chk("R8 ctrl mask", v, 8'hFA);
        chk("R8 irq_tx high", {7'b0, irq_tx}, 8'h01);
        wr(6'h08, 8'h30);
        chk("R8 irq_tx low", {7'b0, irq_tx}, 8'h00);
        wr(6'h18, 8'h00);
    endtask

    task automatic t_unmapped();
        logic [7:0] v;
        wr(6'h04, 8'hFF); wr(6'h1C, 8'hFF); wr(6'h24, 8'hFF); wr(6'h2C, 8'hFF);
        rd(6'h04, v); chk("R13 read 0x04", v, 8'h00);
        rd(6'h24, v); chk("R13 read 0x24", v, 8'h00);
        rd(6'h2C, v); chk("R13 read 0x2C", v, 8'h00);
        rd(6'h08, v); chk("R13 ctrl untouched", v, 8'h30);
        rd(6'h18, v); chk("R13 fctl untouched", v, 8'h00);
    endtask

    task automatic t_tx();
        logic [7:0] v;
        wr(6'h0C, 8'hA5);
        chk("R6 tx strobe+data", {tx_strobe ? 8'hA5 : 8'h00} & tx_data, 8'hA5);
        @(negedge clk);
        chk("R6 strobe one cycle", {7'b0, tx_strobe}, 8'h00);
        rd(6'h10, v); chk("R6 tde cleared", v, 8'h40);
        rd(6'h10, v); chk("R9 read refills tx flags", v, 8'h60);
    endtask

    task automatic t_tend();
        logic [7:0] v;
        wr(6'h08, 8'h10);
        wr(6'h10, 8'h9F);
        rd(6'h10, v); chk("R7 w0c tend/tde", v, 8'h00);
        rd(6'h10, v); chk("R9 no refill when tx off", v, 8'h00);
        wr(6'h08, 8'h10);
        rd(6'h10, v); chk("R8 tx disable sets tend", v, 8'h40);
        wr(6'h08, 8'h30);
    endtask

    task automatic t_rx_basic();
        logic [7:0] v;
        wr(6'h08, 8'h70); wr(6'h18, 8'h00);
        push(8'h11);
        rd(6'h10, v); chk("R3 trig1 rdf+dr", v & 8'h13, 8'h03);
        chk("R4 irq_rx set", {7'b0, irq_rx}, 8'h01);
        rd(6'h14, v); chk("R5 pop data", v, 8'h11);
        rd(6'h10, v); chk("R5 rdf drop", v & 8'h02, 8'h00);
        chk("R4 irq holds after pop", {7'b0, irq_rx}, 8'h01);
        wr(6'h10, 8'hFD);
        chk("R4 irq cleared by bit1", {7'b0, irq_rx}, 8'h00);
        rd(6'h10, v); chk("R7 dr kept with 1", v & 8'h03, 8'h01);
        wr(6'h10, 8'hFE);
        rd(6'h10, v); chk("R7 dr cleared", v & 8'h03, 8'h00);
    endtask

    task automatic t_trig4();
        logic [7:0] v;
        wr(6'h18, 8'h40);
        for (int i = 0; i < 3; i++) push(8'h20 + 8'(i));
        rd(6'h10, v); chk("R3 below trig4", v & 8'h02, 8'h00);
        chk("R4 no irq below trig", {7'b0, irq_rx}, 8'h00);
        push(8'h23);
        rd(6'h10, v); chk("R3 at trig4", v & 8'h02, 8'h02);
        chk("R4 irq at trig", {7'b0, irq_rx}, 8'h01);
        rd(6'h14, v); chk("R5 fifo order", v, 8'h20);
        rd(6'h10, v); chk("R5 rdf drop at 3", v & 8'h02, 8'h00);
        wr(6'h08, 8'h30);
        chk("R4 irq cleared by ctrl", {7'b0, irq_rx}, 8'h00);
        wr(6'h18, 8'h42);
        rd(6'h14, v); chk("R10 fifo flushed", v, 8'h00);
        rd(6'h18, v); chk("R10 fctl keeps trigger", v, 8'h40);
        wr(6'h10, 8'hFE);
    endtask

    task automatic t_full_wrap();
        logic [7:0] v;
        wr(6'h18, 8'hC0);
        for (int i = 0; i < 13; i++) push(8'h40 + 8'(i));
        rd(6'h10, v); chk("R3 below trig14", v & 8'h02, 8'h00);
        push(8'h4D);
        rd(6'h10, v); chk("R3 at trig14", v & 8'h02, 8'h02);
        push(8'h4E); push(8'h4F); push(8'hEE);
        for (int i = 0; i < 16; i++) begin
            rd(6'h14, v); chk("R1 full read order", v, 8'h40 + 8'(i));
            if (i == 0) begin
                rd(6'h10, v); chk("R5 rdf held at 15", v & 8'h02, 8'h02);
            end
            if (i == 2) begin
                rd(6'h10, v); chk("R5 rdf drop at 13", v & 8'h02, 8'h00);
            end
        end
        rd(6'h14, v); chk("R1 overflow dropped", v, 8'h00);
        for (int i = 0; i < 5; i++) push(8'h80 + 8'(i));
        for (int i = 0; i < 5; i++) begin
            rd(6'h14, v); chk("R5 order across wrap", v, 8'h80 + 8'(i));
        end
        wr(6'h10, 8'hFC);
        wr(6'h18, 8'h00);
    endtask

    task automatic t_rx_disabled();
        logic [7:0] v;
        wr(6'h08, 8'h20);
        push(8'h99);
        rd(6'h10, v); chk("R2 no dr when disabled", v & 8'h03, 8'h00);
        wr(6'h08, 8'h30);
        rd(6'h14, v); chk("R2 byte not stored", v, 8'h00);
        push(8'h5A);
        rd(6'h10, v); chk("R11 dr on store", v & 8'h01, 8'h01);
        rd(6'h14, v); chk("R2 enabled store", v, 8'h5A);
        wr(6'h10, 8'hFC);
    endtask

    task automatic t_break();
        logic [7:0] v;
        @(negedge clk); rx_break = 1'b1;
        @(negedge clk); rx_break = 1'b0;
        rd(6'h10, v); chk("R11 break set", v & 8'h10, 8'h10);
        wr(6'h10, 8'hFF);
        rd(6'h10, v); chk("R7 write 1 keeps brk", v & 8'h10, 8'h10);
        wr(6'h10, 8'hEF);
        rd(6'h10, v); chk("R7 brk cleared", v & 8'h10, 8'h00);
    endtask

    task automatic t_irq_gate();
        logic [7:0] v;
        wr(6'h08, 8'h30);
        push(8'h61);
        rd(6'h10, v); chk("R3 rdf without rie", v & 8'h02, 8'h02);
        chk("R4 no irq without rie", {7'b0, irq_rx}, 8'h00);
        rd(6'h14, v);
        wr(6'h08, 8'h70);
        push(8'h62);
        chk("R4 irq with rie", {7'b0, irq_rx}, 8'h01);
        wr(6'h10, 8'hFE);
        chk("R4 irq cleared by bit0", {7'b0, irq_rx}, 8'h00);
        rd(6'h14, v); chk("R5 pop after irq", v, 8'h62);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=0x00 expected=0x01");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_masks();
        t_unmapped();
        t_tx();
        t_tend();
        t_rx_basic();
        t_trig4();
        t_full_wrap();
        t_rx_disabled();
        t_break();
        t_irq_gate();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule